// File: doc/BRIEF.md
# Clock frequency accuracy monitor

The monitor checks whether a target clock runs at its expected rate. It runs on the target clock and counts target cycles across a window. A slower reference clock defines that window. The reference comes from an external pin or from one of several internal oscillator lines, picked by a select input. The chosen reference passes through a two-flop synchronizer into the target domain, where its rising edges are detected. A prescaler then keeps one rising edge in 1, 4, 8 or 32. The window opens on the first prescaled edge and closes on the next one. At the close, the count is captured and compared with a programmed lower limit and upper limit.

The controller has three states. IDLE waits for a start pulse (transition IDLE→ARM). ARM waits for the first prescaled edge, clears the counter and moves to MEAS (transition ARM→MEAS). MEAS counts target cycles until the next prescaled edge. At that edge the result is captured, the done event fires and the error event may fire. The controller then takes one of two transitions. MEAS→MEAS happens when continuous mode is on: the closing edge also opens the next window. MEAS→IDLE happens otherwise. Software or a fail-safe supervisor uses the two events to spot a drifting or dead clock.

Top module: `cfm_monitor`

## Requirements
- R1: `ref_sel_i` = 0 selects `ref_ext_i`. `ref_sel_i` = k (1..N_INT) selects `ref_int_i[k-1]`. Only the selected source sets the window timing.
- R2: A reference level sampled high at clock edge n, after a low sample at edge n-1, counts as a rising edge at clock edge n+2. This follows from the two-flop synchronizer plus the edge detector.
- R3: `div_sel_i` code 0, 1, 2 or 3 keeps every 1st, 4th, 8th or 32nd rising reference edge. Only kept edges open or close a window. The prescaler is cleared in IDLE.
- R4: The captured count equals the number of target clock cycles from the clock edge that opens the window to the clock edge that closes it.
- R5: The count saturates at 2^CNT_W-1 and never wraps.
- R6: `done_o` is a one-cycle pulse. It is high in the cycle after the closing edge. `count_o` updates in that same cycle and then holds.
- R7: `err_o` is high together with `done_o` when the captured count is below `lim_lo_i` or above `lim_hi_i`. A count equal to either limit gives no error.
- R8: `start_i` has no effect outside IDLE.
- R9: With `cont_i` high at the closing edge, the next window begins on that same edge, with no gap.
- R10: With `cont_i` low at the closing edge, the block returns to IDLE. It raises no further `done_o` until a new start.
- R11: After reset the block is in IDLE, and `done_o`, `err_o` and `count_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_tgt | input | 1 | Target clock under measurement; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_ext_i | input | 1 | External reference clock, asynchronous |
| ref_int_i | input | N_INT | Internal oscillator reference lines, asynchronous |
| ref_sel_i | input | $clog2(N_INT+1) | Reference source select |
| div_sel_i | input | 2 | Prescaler code (1/4/8/32) |
| start_i | input | 1 | Start pulse, acted on only in IDLE |
| cont_i | input | 1 | Continuous measurement enable |
| lim_lo_i | input | CNT_W | Lower allowed count |
| lim_hi_i | input | CNT_W | Upper allowed count |
| done_o | output | 1 | Measurement-complete pulse |
| err_o | output | 1 | Out-of-range pulse, coincident with done |
| count_o | output | CNT_W | Last captured count |

## Verification
The bench builds the monitor with CNT_W = 8 and N_INT = 3. The narrow counter lets a 32-edge window of an 18-cycle reference run past 255 in a few hundred cycles, so the saturation path is reached quickly. Three internal lines plus the external pin fill every code of the 2-bit select, so every select code is exercised. Each source is a square wave with a different period. Each prescaler code then gives a distinct, known count, including a count that sits exactly on both limits.

// File: rtl/cfm_pkg.sv
package cfm_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_MEAS = 2'd2
    } cfm_state_e;

    localparam int PRESC_W = 5;

    // Index of the last kept edge within one prescaler cycle.
    function automatic logic [PRESC_W-1:0] presc_last(input logic [1:0] code);
        logic [PRESC_W-1:0] v;
        unique case (code)
            2'd0:    v = PRESC_W'(0);
            2'd1:    v = PRESC_W'(3);
            2'd2:    v = PRESC_W'(7);
            default: v = PRESC_W'(31);
        endcase
        return v;
    endfunction

endpackage

// File: rtl/cfm_ref_front.sv
module cfm_ref_front
    import cfm_pkg::*;
#(
    parameter int N_INT       = 3,
    parameter int SYNC_STAGES = 2,
    parameter int SEL_W       = $clog2(N_INT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_ext_i,
    input  logic [N_INT-1:0] ref_int_i,
    input  logic [SEL_W-1:0] ref_sel_i,
    input  logic [1:0]       div_sel_i,
    input  logic             run_i,
    output logic             tick_o
);

    logic                   ref_mux;
    logic [SYNC_STAGES:0]   pipe_q;
    logic                   rise;
    logic [PRESC_W-1:0]     presc_q;
    logic [PRESC_W-1:0]     last;

    always_comb begin
        ref_mux = ref_ext_i;
        for (int i = 0; i < N_INT; i++) begin
            if (ref_sel_i == SEL_W'(i + 1)) ref_mux = ref_int_i[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= {pipe_q[SYNC_STAGES-1:0], ref_mux};
    end

    assign rise = pipe_q[SYNC_STAGES-1] & ~pipe_q[SYNC_STAGES];
    assign last = presc_last(div_sel_i);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        presc_q <= '0;
        else if (!run_i)   presc_q <= '0;
        else if (rise)     presc_q <= (presc_q >= last) ? '0 : presc_q + 1'b1;
    end

    assign tick_o = run_i & rise & (presc_q >= last);

    // R2: edge detector on a synchronized level never fires twice in a row
    p_rise_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

    // R3: prescaler holds no stale phase outside a measurement
    p_presc_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> presc_q == '0);

endmodule

// File: rtl/cfm_win_counter.sv
module cfm_win_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] cap_o
);

    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [CNT_W-1:0] cnt_q;

    // Saturating successor, used both for counting and for capture.
    assign cap_o = (cnt_q == CNT_MAX) ? CNT_MAX : cnt_q + 1'b1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     cnt_q <= '0;
        else if (clr_i) cnt_q <= '0;
        else if (inc_i) cnt_q <= cap_o;
    end

    p_sat_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);

    p_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !clr_i) |=> cnt_q >= $past(cnt_q));

endmodule

// File: rtl/cfm_ctrl.sv
module cfm_ctrl
    import cfm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] cap_i,
    input  logic [CNT_W-1:0] lim_lo_i,
    input  logic [CNT_W-1:0] lim_hi_i,
    output logic             run_o,
    output logic             clr_o,
    output logic             inc_o,
    output logic             done_o,
    output logic             err_o,
    output logic [CNT_W-1:0] count_o
);

    cfm_state_e state_q, state_d;
    logic       close_win;

    assign close_win = (state_q == ST_MEAS) && tick_i;
    assign run_o     = (state_q != ST_IDLE);
    assign clr_o     = tick_i && (state_q != ST_IDLE);
    assign inc_o     = (state_q == ST_MEAS) && !tick_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start_i) state_d = ST_ARM;
            ST_ARM:  if (tick_i)  state_d = ST_MEAS;
            ST_MEAS: if (tick_i)  state_d = cont_i ? ST_MEAS : ST_IDLE;
            default:              state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done_o  <= 1'b0;
            err_o   <= 1'b0;
            count_o <= '0;
        end else begin
            done_o <= close_win;
            err_o  <= close_win && ((cap_i < lim_lo_i) || (cap_i > lim_hi_i));
            if (close_win) count_o <= cap_i;
        end
    end

    p_err_with_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> done_o);

    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !tick_i) |=> state_q == $past(state_q));

    p_cont_chain_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (close_win && cont_i) |=> state_q == ST_MEAS);

    p_single_stop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (close_win && !cont_i) |=> state_q == ST_IDLE);

endmodule

// File: rtl/cfm_monitor.sv
module cfm_monitor #(
    parameter int N_INT = 3,
    parameter int CNT_W = 16,
    localparam int SEL_W = $clog2(N_INT + 1)
) (
    input  logic             clk_tgt,
    input  logic             rst_n,
    input  logic             ref_ext_i,
    input  logic [N_INT-1:0] ref_int_i,
    input  logic [SEL_W-1:0] ref_sel_i,
    input  logic [1:0]       div_sel_i,
    input  logic             start_i,
    input  logic             cont_i,
    input  logic [CNT_W-1:0] lim_lo_i,
    input  logic [CNT_W-1:0] lim_hi_i,
    output logic             done_o,
    output logic             err_o,
    output logic [CNT_W-1:0] count_o
);

    logic             run;
    logic             tick;
    logic             clr;
    logic             inc;
    logic [CNT_W-1:0] cap;

    cfm_ref_front #(.N_INT(N_INT), .SYNC_STAGES(2), .SEL_W(SEL_W)) u_front (
        .clk       (clk_tgt),
        .rst_n     (rst_n),
        .ref_ext_i (ref_ext_i),
        .ref_int_i (ref_int_i),
        .ref_sel_i (ref_sel_i),
        .div_sel_i (div_sel_i),
        .run_i     (run),
        .tick_o    (tick)
    );

    cfm_win_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk_tgt),
        .rst_n (rst_n),
        .clr_i (clr),
        .inc_i (inc),
        .cap_o (cap)
    );

    cfm_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk      (clk_tgt),
        .rst_n    (rst_n),
        .start_i  (start_i),
        .cont_i   (cont_i),
        .tick_i   (tick),
        .cap_i    (cap),
        .lim_lo_i (lim_lo_i),
        .lim_hi_i (lim_hi_i),
        .run_o    (run),
        .clr_o    (clr),
        .inc_o    (inc),
        .done_o   (done_o),
        .err_o    (err_o),
        .count_o  (count_o)
    );

endmodule

// File: tb/tb_cfm_monitor.sv
module tb_cfm_monitor;

    localparam int CLK_PERIOD = 10;
    localparam int N_INT      = 3;
    localparam int CNT_W      = 8;
    localparam int SEL_W      = $clog2(N_INT + 1);
    localparam int CMAX       = (1 << CNT_W) - 1;
    localparam int WDOG       = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ref_ext;
    logic [N_INT-1:0] ref_int;
    logic [SEL_W-1:0] ref_sel = '0;
    logic [1:0]       div_sel = '0;
    logic             start = 1'b0;
    logic             cont = 1'b0;
    logic [CNT_W-1:0] lim_lo = '0;
    logic [CNT_W-1:0] lim_hi = '1;
    logic             done_o, err_o;
    logic [CNT_W-1:0] count_o;

    int n_cmp = 0, n_bad = 0, n_done = 0, cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cfm_monitor #(.N_INT(N_INT), .CNT_W(CNT_W)) dut (
        .clk_tgt(clk), .rst_n(rst_n), .ref_ext_i(ref_ext), .ref_int_i(ref_int),
        .ref_sel_i(ref_sel), .div_sel_i(div_sel), .start_i(start), .cont_i(cont),
        .lim_lo_i(lim_lo), .lim_hi_i(lim_hi), .done_o(done_o), .err_o(err_o),
        .count_o(count_o));

    // Reference square waves: half periods in target cycles (ext, int0, int1, int2).
    int  halfp [4] = '{6, 5, 9, 3};
    int  gcnt  [4] = '{0, 0, 0, 0};
    bit  gval  [4] = '{0, 0, 0, 0};
    always @(negedge clk) begin
        for (int k = 0; k < 4; k++) begin
            gcnt[k] = gcnt[k] + 1;
            if (gcnt[k] >= halfp[k]) begin gcnt[k] = 0; gval[k] = ~gval[k]; end
        end
    end
    assign ref_ext = gval[0];
    assign ref_int = {gval[3], gval[2], gval[1]};

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    // Behavioural reference model, advanced on each rising edge.
    int h0 = 0, h1 = 0, h2 = 0;
    int mstate = 0, mdiv = 0, mcnt = 0;
    int e_done = 0, e_err = 0, e_count = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            h0 = 0; h1 = 0; h2 = 0; mstate = 0; mdiv = 0; mcnt = 0;
            e_done = 0; e_err = 0; e_count = 0;
        end else begin
            int selv, rise, lastk, run, tick, v;
            selv  = (ref_sel == 0) ? int'(ref_ext) : int'(ref_int[ref_sel - 1]);
            rise  = (h1 == 1 && h2 == 0) ? 1 : 0;
            lastk = (div_sel == 0) ? 0 : (div_sel == 1) ? 3 : (div_sel == 2) ? 7 : 31;
            run   = (mstate != 0) ? 1 : 0;
            tick  = (run == 1 && rise == 1 && mdiv == lastk) ? 1 : 0;
            e_done = 0; e_err = 0;
            case (mstate)
                0: if (start) mstate = 1;
                1: if (tick == 1) begin mstate = 2; mcnt = 0; end
                default: begin
                    if (tick == 1) begin
                        v = (mcnt + 1 > CMAX) ? CMAX : mcnt + 1;
                        e_count = v; e_done = 1;
                        e_err = (v < int'(lim_lo) || v > int'(lim_hi)) ? 1 : 0;
                        mstate = cont ? 2 : 0;
                        mcnt = 0;
                    end else mcnt = (mcnt + 1 > CMAX) ? CMAX : mcnt + 1;
                end
            endcase
            if (run == 0) mdiv = 0;
            else if (rise == 1) mdiv = (mdiv == lastk) ? 0 : mdiv + 1;
            h2 = h1; h1 = h0; h0 = selv;
        end
    end

    // Per-cycle comparison, away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            check(int'(done_o) == e_done, "R6 R2 done", int'(done_o), e_done);
            check(int'(err_o) == e_err, "R7 err", int'(err_o), e_err);
            check(int'(count_o) == e_count, "R4 count", int'(count_o), e_count);
            if (done_o) n_done++;
        end
        cyc++;
        if (cyc > WDOG) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected<%0d", cyc, WDOG);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done(output int c, output int e);
        int t = 0;
        c = -1; e = -1;
        while (t < 3000) begin
            @(negedge clk); #1;
            if (done_o) begin c = int'(count_o); e = int'(err_o); break; end
            t++;
        end
    endtask

    task automatic setup(input int s, input int d, input int lo, input int hi, input bit c);
        @(negedge clk);
        ref_sel = SEL_W'(s); div_sel = 2'(d);
        lim_lo = CNT_W'(lo); lim_hi = CNT_W'(hi); cont = c;
        repeat (6) @(negedge clk);
    endtask

    initial begin
        int c, e, base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        check(done_o == 1'b0 && err_o == 1'b0, "R11 reset flags", int'(done_o) + int'(err_o), 0);
        check(count_o == '0, "R11 reset count", int'(count_o), 0);

        // R1 R4: external reference, period 12, prescale 1
        setup(0, 0, 10, 14, 1'b0);
        pulse_start();
        wait_done(c, e);
        check(c == 12, "R1 R4 ext window", c, 12);
        check(e == 0, "R7 in range", e, 0);

        // R10: single mode, no more events without a start
        base = n_done;
        repeat (60) @(negedge clk);
        check(n_done == base, "R10 idle after single", n_done - base, 0);

        // R3 R7: int0 period 10, prescale 4 -> 40, below lower limit
        setup(1, 1, 41, 50, 1'b0);
        pulse_start();
        wait_done(c, e);
        check(c == 40, "R3 div4 count", c, 40);
        check(e == 1, "R7 below lower", e, 1);

        // R3 R7: int2 period 6, prescale 8 -> 48, equal to both limits
        setup(3, 2, 48, 48, 1'b0);
        pulse_start();
        wait_done(c, e);
        check(c == 48, "R3 div8 count", c, 48);
        check(e == 0, "R7 on limits", e, 0);

        // R5: int1 period 18, prescale 32 -> 576, saturates
        setup(2, 3, 0, CMAX, 1'b0);
        pulse_start();
        wait_done(c, e);
        check(c == CMAX, "R5 saturation", c, CMAX);

        // R9 R8: continuous, above upper limit, start pulses while busy
        setup(0, 0, 0, 11, 1'b1);
        pulse_start();
        wait_done(c, e);
        check(e == 1, "R7 above upper", e, 1);
        base = n_done;
        repeat (20) @(negedge clk);
        pulse_start();
        repeat (80) @(negedge clk);
        check(n_done - base >= 7, "R9 back-to-back windows", n_done - base, 8);
        check(int'(count_o) == 12, "R8 start ignored, count", int'(count_o), 12);

        // R10: leave continuous mode, last window ends then idle
        @(negedge clk); cont = 1'b0;
        wait_done(c, e);
        check(c == 12, "R10 final window", c, 12);
        base = n_done;
        repeat (50) @(negedge clk);
        check(n_done == base, "R10 stopped", n_done - base, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule